// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Near-Boundary Flags

This block is a first-in first-out buffer between two unrelated clock domains. A producer writes 9-bit words on its own free-running clock, and a consumer takes them out on a second clock. The two clocks may be fully asynchronous or tied to one source. A port acts only when both of its two enables are high. Stray single-enable activity therefore never moves the buffer.

The buffer raises empty and full, plus two early-warning flags. Each early-warning flag compares the fill level with an offset register. The near-empty offset is loaded by a strobe in the read domain, and the near-full offset by a strobe in the write domain. Both offsets come out of reset at seven. The read word is held in a register and passes through an output-enable gate. When the gate is closed the bus is driven to zero, which stands in for a released tri-state bus.

The nominal depth is 8192 entries (`AW=13`). The default elaboration uses `AW=10`, which keeps the inferred block RAM small. The bench uses `AW=5`, so the depth is 32.

Top module: `dcfifo_flags`

## Requirements
- R1: A word is stored at a rising `wr_clk` edge only if `wr_en_a` and `wr_en_b` are both 1 and `is_full` is 0. A single write enable stores nothing.
- R2: A read is accepted at a rising `rd_clk` edge only if `rd_en_a` and `rd_en_b` are both 1 and `is_empty` is 0. The accepted word is on `rd_data` after that edge, and it is held until the next accepted read.
- R3: Words leave in the order they were written, with `wr_clk` and `rd_clk` unrelated.
- R4: `is_empty` is 1 exactly when no word is stored. `is_full` is 1 exactly when 2^AW words are stored. Both are valid once the pointer synchronizers have settled.
- R5: A write attempted while `is_full` is 1 is dropped: no stored word is overwritten and no extra word is added.
- R6: A read attempted while `is_empty` is 1 is dropped: `rd_data` keeps its value and later reads return the correct words.
- R7: `near_empty` is 1 when the fill level is at or below the near-empty offset. With the reset offset of 7, it is 1 at 7 words and 0 at 8 words.
- R8: `near_full` is 1 when the fill level is at or above 2^AW minus the near-full offset. With the reset offset of 7 and a depth of 32, it is 0 at 24 words and 1 at 25 words.
- R9: A one-cycle `ae_load` strobe on `rd_clk` loads `ae_value` as the near-empty offset. A one-cycle `af_load` strobe on `wr_clk` loads `af_value` as the near-full offset. Values from 0 to 2^AW-1 are accepted.
- R10: Reset makes `is_empty` and `near_empty` 1 and `is_full` and `near_full` 0. It empties the buffer and returns both offsets to 7.
- R11: While `rd_oe` is 0, `rd_data` is all zeros. Setting `rd_oe` back to 1 shows the held word again.
- R12: Each pointer crosses its clock boundary in Gray code, changing by at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en_a | input | 1 | First write enable |
| wr_en_b | input | 1 | Second write enable |
| wr_data | input | DW | Word to store |
| af_load | input | 1 | Strobe that loads the near-full offset |
| af_value | input | AW | New near-full offset |
| is_full | output | 1 | Buffer holds 2^AW words |
| near_full | output | 1 | Level at or above 2^AW minus the near-full offset |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| rd_oe | input | 1 | Output gate; 0 drives `rd_data` to zero |
| ae_load | input | 1 | Strobe that loads the near-empty offset |
| ae_value | input | AW | New near-empty offset |
| rd_data | output | DW | Held read word, gated by `rd_oe` |
| is_empty | output | 1 | Buffer holds no word |
| near_empty | output | 1 | Level at or below the near-empty offset |

## Verification
Corrupt pointer state shows up in two ways at the ports. It can show as a word out of sequence or a repeated word at the next accepted read. It can also show as a flag that disagrees with the model level a few cycles after traffic stops. A pointer that advances on a blocked write or read is found in the very next drained word, because that word then differs from the scoreboard. Wrong offset registers show up within one settled level step, since the bench walks the fill level across each threshold one word at a time.

// File: rtl/dcfifo_pkg.sv
`timescale 1ns/1ps
package dcfifo_pkg;
  // Distance of the near flags from the buffer ends after reset
  localparam int unsigned DEF_GAP = 7;

  // Flags produced by one side: the hard boundary and its early warning
  typedef struct packed {
    logic bound;
    logic close;
  } flag_pair_t;
endpackage

// File: rtl/dcfifo_sync.sv
`timescale 1ns/1ps
module dcfifo_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dcfifo_store.sv
`timescale 1ns/1ps
module dcfifo_store #(
  parameter int DW = 9,
  parameter int AW = 10
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rq
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rrst)    rq <= '0;
    else if (re) rq <= mem[raddr];
  end
endmodule

// File: rtl/dcfifo_wr_side.sv
`timescale 1ns/1ps
module dcfifo_wr_side
  import dcfifo_pkg::*;
#(
  parameter int AW  = 10,
  parameter int GAP = DEF_GAP
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW:0]   rgray_s,
  input  logic          off_load,
  input  logic [AW-1:0] off_value,
  output logic [AW-1:0] waddr,
  output logic          mem_we,
  output logic [AW:0]   wgray,
  output flag_pair_t    flags
);
  localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW:0]   wbin, wbin_nx, wgray_nx, rbin_s, lvl_nx, thr;
  logic [AW-1:0] off_q;
  logic          accept, full_nx;

  assign accept   = push & ~flags.bound;
  assign wbin_nx  = wbin + {{AW{1'b0}}, accept};
  assign wgray_nx = (wbin_nx >> 1) ^ wbin_nx;
  assign rbin_s   = g2b(rgray_s);
  assign lvl_nx   = wbin_nx - rbin_s;
  assign thr      = DEPTH_V - {1'b0, off_q};
  // Full: write pointer one lap ahead of the synchronized read pointer
  assign full_nx  = (wgray_nx == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin        <= '0;
      wgray       <= '0;
      flags.bound <= 1'b0;
      flags.close <= 1'b0;
    end else begin
      wbin        <= wbin_nx;
      wgray       <= wgray_nx;
      flags.bound <= full_nx;
      flags.close <= (lvl_nx >= thr);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           off_q <= AW'(GAP);
    else if (off_load) off_q <= off_value;
  end

  assign waddr  = wbin[AW-1:0];
  assign mem_we = accept;
endmodule

// File: rtl/dcfifo_rd_side.sv
`timescale 1ns/1ps
module dcfifo_rd_side
  import dcfifo_pkg::*;
#(
  parameter int AW  = 10,
  parameter int GAP = DEF_GAP
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop,
  input  logic [AW:0]   wgray_s,
  input  logic          off_load,
  input  logic [AW-1:0] off_value,
  output logic [AW-1:0] raddr,
  output logic          mem_re,
  output logic [AW:0]   rgray,
  output flag_pair_t    flags
);
  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW:0]   rbin, rbin_nx, rgray_nx, wbin_s, lvl_nx;
  logic [AW-1:0] off_q;
  logic          accept;

  assign accept   = pop & ~flags.bound;
  assign rbin_nx  = rbin + {{AW{1'b0}}, accept};
  assign rgray_nx = (rbin_nx >> 1) ^ rbin_nx;
  assign wbin_s   = g2b(wgray_s);
  assign lvl_nx   = wbin_s - rbin_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin        <= '0;
      rgray       <= '0;
      flags.bound <= 1'b1;
      flags.close <= 1'b1;
    end else begin
      rbin        <= rbin_nx;
      rgray       <= rgray_nx;
      flags.bound <= (rgray_nx == wgray_s);
      flags.close <= (lvl_nx <= {1'b0, off_q});
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           off_q <= AW'(GAP);
    else if (off_load) off_q <= off_value;
  end

  assign raddr  = rbin[AW-1:0];
  assign mem_re = accept;
endmodule

// File: rtl/dcfifo_flags.sv
`timescale 1ns/1ps
module dcfifo_flags
  import dcfifo_pkg::*;
#(
  parameter int DW          = 9,
  parameter int AW          = 10,
  parameter int SYNC_STAGES = 2,
  parameter int GAP_DEFAULT = DEF_GAP
) (
  input  logic          wr_clk,
  input  logic          wr_rst,
  input  logic          wr_en_a,
  input  logic          wr_en_b,
  input  logic [DW-1:0] wr_data,
  input  logic          af_load,
  input  logic [AW-1:0] af_value,
  output logic          is_full,
  output logic          near_full,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          rd_en_a,
  input  logic          rd_en_b,
  input  logic          rd_oe,
  input  logic          ae_load,
  input  logic [AW-1:0] ae_value,
  output logic [DW-1:0] rd_data,
  output logic          is_empty,
  output logic          near_empty
);
  logic [AW:0]   wgray_w, rgray_w, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr;
  logic          mem_we, mem_re;
  logic [DW-1:0] rd_q;
  flag_pair_t    wflags, rflags;

  dcfifo_wr_side #(.AW(AW), .GAP(GAP_DEFAULT)) u_wr (
    .clk(wr_clk), .rst(wr_rst), .push(wr_en_a & wr_en_b), .rgray_s(rgray_s),
    .off_load(af_load), .off_value(af_value), .waddr(waddr), .mem_we(mem_we),
    .wgray(wgray_w), .flags(wflags)
  );

  dcfifo_rd_side #(.AW(AW), .GAP(GAP_DEFAULT)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .pop(rd_en_a & rd_en_b), .wgray_s(wgray_s),
    .off_load(ae_load), .off_value(ae_value), .raddr(raddr), .mem_re(mem_re),
    .rgray(rgray_w), .flags(rflags)
  );

  dcfifo_sync #(.W(AW + 1), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst(rd_rst), .d(wgray_w), .q(wgray_s)
  );

  dcfifo_sync #(.W(AW + 1), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst(wr_rst), .d(rgray_w), .q(rgray_s)
  );

  dcfifo_store #(.DW(DW), .AW(AW)) u_mem (
    .wclk(wr_clk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .rrst(rd_rst), .re(mem_re), .raddr(raddr), .rq(rd_q)
  );

  assign is_full    = wflags.bound;
  assign near_full  = wflags.close;
  assign is_empty   = rflags.bound;
  assign near_empty = rflags.close;
  assign rd_data    = rd_oe ? rd_q : '0;
endmodule

// File: rtl/dcfifo_flags_chk.sv
`timescale 1ns/1ps
module dcfifo_flags_chk #(
  parameter int DW = 9,
  parameter int AW = 10
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          wr_rst,
  input logic          rd_rst,
  input logic          wr_en_a,
  input logic          wr_en_b,
  input logic          rd_en_a,
  input logic          rd_en_b,
  input logic          is_empty,
  input logic          is_full,
  input logic          near_empty,
  input logic          near_full,
  input logic [AW:0]   wgray,
  input logic [AW:0]   rgray,
  input logic [DW-1:0] rd_q
);
  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (is_full && wr_en_a && wr_en_b) |=> $stable(wgray));  // R5
  AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (is_empty && rd_en_a && rd_en_b) |=> ($stable(rgray) && $stable(rd_q)));  // R6
  AST_WR_NEEDS_BOTH: assert property (@(posedge wr_clk) disable iff (wr_rst)
    !(wr_en_a && wr_en_b) |=> $stable(wgray));  // R1
  AST_RD_NEEDS_BOTH: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !(rd_en_a && rd_en_b) |=> ($stable(rgray) && $stable(rd_q)));  // R2
  AST_WGRAY_STEP: assert property (@(posedge wr_clk) disable iff (wr_rst)
    $onehot0(wgray ^ $past(wgray)));  // R12
  AST_RGRAY_STEP: assert property (@(posedge rd_clk) disable iff (rd_rst)
    $onehot0(rgray ^ $past(rgray)));  // R12
  AST_EMPTY_IS_NEAR: assert property (@(posedge rd_clk) disable iff (rd_rst)
    is_empty |-> near_empty);  // R7
  AST_FULL_IS_NEAR: assert property (@(posedge wr_clk) disable iff (wr_rst)
    is_full |-> near_full);  // R8
endmodule

bind dcfifo_flags dcfifo_flags_chk #(.DW(DW), .AW(AW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst(wr_rst), .rd_rst(rd_rst),
  .wr_en_a(wr_en_a), .wr_en_b(wr_en_b), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b),
  .is_empty(is_empty), .is_full(is_full), .near_empty(near_empty),
  .near_full(near_full), .wgray(wgray_w), .rgray(rgray_w), .rd_q(rd_q)
);

// File: tb/test_dcfifo_flags.sv
`timescale 1ns/1ps
module test_dcfifo_flags;
  localparam int DW    = 9;
  localparam int AW    = 5;
  localparam int DEPTH = 1 << AW;

  logic          wr_clk = 0, rd_clk = 0;
  logic          wr_rst = 1, rd_rst = 1;
  logic          wr_en_a = 0, wr_en_b = 0, rd_en_a = 0, rd_en_b = 0;
  logic          rd_oe = 1, af_load = 0, ae_load = 0;
  logic [AW-1:0] af_value = '0, ae_value = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          is_full, near_full, is_empty, near_empty;

  int            checks = 0, failures = 0;
  logic [DW-1:0] sb[$];
  logic [DW-1:0] wval = '0;
  logic [DW-1:0] last_rd = '0;
  bit            wd_hit = 0;

  always #5    wr_clk = ~wr_clk;   // 100 MHz
  always #6.85 rd_clk = ~rd_clk;   // unrelated read clock

  dcfifo_flags #(.DW(DW), .AW(AW)) i_dcfifo_flags (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
    repeat (6) @(negedge wr_clk);
  endtask

  task automatic chk_rd_flags(input string req, input bit e, input bit ne);
    @(negedge rd_clk);
    check(is_empty == e, req, "is_empty", int'(is_empty), int'(e));
    check(near_empty == ne, req, "near_empty", int'(near_empty), int'(ne));
  endtask

  task automatic chk_wr_flags(input string req, input bit f, input bit nf);
    @(negedge wr_clk);
    check(is_full == f, req, "is_full", int'(is_full), int'(f));
    check(near_full == nf, req, "near_full", int'(near_full), int'(nf));
  endtask

  // Driver: one accepted write, expected word pushed to the scoreboard
  task automatic write_one();
    do @(negedge wr_clk); while (is_full);
    wr_data = wval;
    wr_en_a = 1; wr_en_b = 1;
    sb.push_back(wval);
    wval = wval + 9'd37;
    @(negedge wr_clk);
    wr_en_a = 0; wr_en_b = 0;
  endtask

  task automatic write_n(input int n);
    for (int i = 0; i < n; i++) write_one();
  endtask

  // Monitor: one accepted read compared against the scoreboard head
  task automatic read_one(input string req);
    logic [DW-1:0] exp;
    do @(negedge rd_clk); while (is_empty);
    rd_en_a = 1; rd_en_b = 1;
    @(negedge rd_clk);
    rd_en_a = 0; rd_en_b = 0;
    if (sb.size() == 0) begin
      check(0, req, "read with empty scoreboard", int'(rd_data), -1);
    end else begin
      exp = sb.pop_front();
      check(rd_data == exp, req, "rd_data order", int'(rd_data), int'(exp));
      last_rd = exp;
    end
  endtask

  task automatic read_n(input int n, input string req);
    for (int i = 0; i < n; i++) read_one(req);
  endtask

  task automatic do_reset();
    wr_rst = 1; rd_rst = 1;
    repeat (5) @(negedge rd_clk);
    @(negedge wr_clk); wr_rst = 0;
    @(negedge rd_clk); rd_rst = 0;
    sb.delete();
    last_rd = '0;
  endtask

  task automatic run_all();
    do_reset();
    // R10: reset state
    chk_rd_flags("R10", 1, 1);
    chk_wr_flags("R10", 0, 0);
    @(negedge rd_clk);
    check(rd_data == '0, "R10", "rd_data after reset", int'(rd_data), 0);

    // R1: a single write enable stores nothing
    wr_data = 9'h155;
    @(negedge wr_clk); wr_en_a = 1;
    repeat (4) @(negedge wr_clk);
    wr_en_a = 0; wr_en_b = 1;
    repeat (4) @(negedge wr_clk);
    wr_en_b = 0;
    settle();
    chk_rd_flags("R1", 1, 1);

    // R7/R4: default near-empty threshold
    write_n(7); settle();
    chk_rd_flags("R7", 0, 1);
    write_n(1); settle();
    chk_rd_flags("R7", 0, 0);
    // R8: default near-full threshold
    write_n(16); settle();
    chk_wr_flags("R8", 0, 0);
    write_n(1); settle();
    chk_wr_flags("R8", 0, 1);
    write_n(DEPTH - 25); settle();
    chk_wr_flags("R4", 1, 1);

    // R5: writes while full are dropped
    @(negedge wr_clk);
    wr_data = 9'h1AA; wr_en_a = 1; wr_en_b = 1;
    repeat (3) @(negedge wr_clk);
    wr_en_a = 0; wr_en_b = 0;
    settle();
    chk_wr_flags("R5", 1, 1);
    read_n(DEPTH, "R5");
    settle();
    chk_rd_flags("R4", 1, 1);
    chk_wr_flags("R4", 0, 0);

    // R6: reads while empty are dropped
    @(negedge rd_clk); rd_en_a = 1; rd_en_b = 1;
    repeat (5) @(negedge rd_clk);
    rd_en_a = 0; rd_en_b = 0;
    @(negedge rd_clk);
    check(rd_data == last_rd, "R6", "rd_data held", int'(rd_data), int'(last_rd));
    write_n(3);
    read_n(3, "R6");

    // R11: output gate
    @(negedge rd_clk); rd_oe = 0;
    @(negedge rd_clk);
    check(rd_data == '0, "R11", "rd_data gated", int'(rd_data), 0);
    rd_oe = 1;
    @(negedge rd_clk);
    check(rd_data == last_rd, "R11", "rd_data restored", int'(rd_data), int'(last_rd));

    // R2: single read enable does not advance
    write_n(2); settle();
    @(negedge rd_clk); rd_en_a = 1;
    repeat (3) @(negedge rd_clk);
    rd_en_a = 0; rd_en_b = 1;
    repeat (3) @(negedge rd_clk);
    rd_en_b = 0;
    check(rd_data == last_rd, "R2", "rd_data with one enable", int'(rd_data), int'(last_rd));
    read_n(2, "R2");
    settle();

    // R9: programmed offsets
    @(negedge rd_clk); ae_value = 5'd2; ae_load = 1;
    @(negedge rd_clk); ae_load = 0;
    @(negedge wr_clk); af_value = 5'd10; af_load = 1;
    @(negedge wr_clk); af_load = 0;
    write_n(2); settle();
    chk_rd_flags("R9", 0, 1);
    write_n(1); settle();
    chk_rd_flags("R9", 0, 0);
    write_n(18); settle();
    chk_wr_flags("R9", 0, 0);
    write_n(1); settle();
    chk_wr_flags("R9", 0, 1);
    read_n(22, "R9");
    settle();

    // R3: concurrent traffic with random gaps
    fork
      for (int i = 0; i < 300; i++) begin
        repeat ($urandom_range(0, 3)) @(negedge wr_clk);
        write_one();
      end
      for (int i = 0; i < 300; i++) begin
        repeat ($urandom_range(0, 3)) @(negedge rd_clk);
        read_one("R3");
      end
    join
    settle();
    chk_rd_flags("R3", 1, 1);

    // R10: reset mid-fill restores defaults
    write_n(5);
    do_reset();
    chk_rd_flags("R10", 1, 1);
    chk_wr_flags("R10", 0, 0);
    write_n(7); settle();
    chk_rd_flags("R10", 0, 1);
    write_n(1); settle();
    chk_rd_flags("R10", 0, 0);
    write_n(17); settle();
    chk_wr_flags("R10", 0, 1);
    read_n(25, "R10");
  endtask

  initial begin
    fork
      run_all();
      begin #1_500_000; wd_hit = 1; end
    join_any
    disable fork;
    if (wd_hit) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule